// File: doc/BRIEF.md
# Successive approximation conversion controller

This block is the digital half of a successive approximation converter. It drives an N-bit trial code to an external DAC and reads back one comparator bit, high when the analog input is at or above the DAC level. A conversion resolves one bit per clock, from the most significant bit down to the least significant bit. It always takes N clocks, whatever the input amplitude.

A one-cycle start request begins a conversion while the block is idle. Each finished code goes into an output buffer. The buffer keeps the previous sample readable while the next conversion runs, and a one-cycle done pulse marks each update. Each bit is also put out serially, most significant first, together with a valid strobe, in the cycle its comparison is made. With eight bits and a 2 V reference, one code step is 7.8125 mV.

Top module: `sar_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, busy_o, done_o and ser_vld_o are 0, and result_o and dac_code_o are all zeros.
- R2: A start_i seen high at a rising clock edge while busy_o is low begins a conversion. In the next cycle busy_o is 1 and dac_code_o has only bit N-1 set.
- R3: In each busy cycle the bit under test stays 1 if cmp_i is 1 and becomes 0 if cmp_i is 0. The bit below it is then set to 1 for the next comparison. For an ideal comparator (cmp_i = input >= dac_code_o), the result equals the input clamped to the range 0 to 2^N-1.
- R4: busy_o stays high for exactly N consecutive cycles per conversion, for every input value.
- R5: done_o is high for exactly one cycle, the first cycle after the last bit is decided. In that cycle busy_o is low and result_o holds the new code.
- R6: result_o changes only in a cycle where done_o is high. During a conversion it keeps the previous code.
- R7: In each busy cycle ser_vld_o is 1 and ser_bit_o equals the bit decided in that cycle, most significant bit first. ser_vld_o is 0 while idle.
- R8: A start_i request while busy_o is high is ignored. The running conversion keeps its N-cycle length and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, acted on only while idle |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | N | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when result_o updates |
| result_o | output | N | Buffered result of the last conversion |
| ser_bit_o | output | 1 | Serial bit decided in this cycle |
| ser_vld_o | output | 1 | Qualifies ser_bit_o |

## Verification
The assertions check on every cycle that the trial code has the MSB-only pattern at the start of a conversion. They also check that the bits below the pointer stay zero under the probe bit, that the pointer counts down one per busy cycle and busy ends after bit zero, that done lasts one cycle while busy is low, and that the buffer holds between done pulses. Only the bench's scenarios can show that the final code matches the input level: it sweeps every input code plus out-of-range levels against an ideal comparator. The bench also checks the serial bit order against the expected binary value and shows that a held start request leaves the conversion unchanged.

// File: rtl/sar_pkg.sv
package sar_pkg;
  function automatic int unsigned ptr_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = sar_pkg::ptr_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [PW-1:0] ptr_o,
  output logic          load_o,
  output logic          last_o
);
  localparam logic [PW-1:0] TOP = PW'(N - 1);

  assign load_o = start_i && !busy_o;
  assign last_o = busy_o && (ptr_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      ptr_o  <= '0;
    end else if (load_o) begin
      busy_o <= 1'b1;
      ptr_o  <= TOP;
    end else if (busy_o) begin
      if (ptr_o == '0) busy_o <= 1'b0;
      else             ptr_o  <= ptr_o - 1'b1;
    end
  end

  a_r4_ptr_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ptr_o != '0) |=> (busy_o && ptr_o == $past(ptr_o) - 1'b1));
  a_r4_ends_after_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ptr_o == '0) |=> !busy_o);
  a_r2_start_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ptr_o == TOP));
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = sar_pkg::ptr_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          cmp_i,
  output logic [N-1:0]  trial_o,
  output logic [N-1:0]  final_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic here, next;
    assign here = (ptr_i == PW'(i));
    if (i < N - 1) begin : g_below
      assign next = (ptr_i == PW'(i + 1));
    end else begin : g_top
      assign next = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  trial_o[i] <= 1'b0;
      else if (load_i)              trial_o[i] <= (i == N - 1);
      else if (busy_i && here)      trial_o[i] <= cmp_i;
      else if (busy_i && next)      trial_o[i] <= 1'b1;
    end
  end

  // last decision lands straight in the buffer
  assign final_o = {trial_o[N-1:1], cmp_i};

  logic [N-1:0] low_mask;
  assign low_mask = (N'(1) << ptr_i) - N'(1);

  a_r3_probe_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (trial_o[ptr_i] == 1'b1));
  a_r3_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ((trial_o & low_mask) == '0));
  a_r2_msb_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (trial_o == (N'(1) << (N - 1))));
endmodule

// File: rtl/sar_outbuf.sv
module sar_outbuf #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         last_i,
  input  logic [N-1:0] final_i,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) result_o <= final_i;
    end
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (result_o == $past(result_o)) or $rose(done_o) or !$past(rst_ni));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o,
  output logic         ser_bit_o,
  output logic         ser_vld_o
);
  localparam int unsigned PW = sar_pkg::ptr_width(N);

  logic [PW-1:0] ptr;
  logic          load, last;
  logic [N-1:0]  final_code;

  sar_seq #(.N(N), .PW(PW)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .ptr_o(ptr), .load_o(load), .last_o(last)
  );

  sar_trial #(.N(N), .PW(PW)) u_trial (
    .clk_i, .rst_ni, .load_i(load), .busy_i(busy_o), .ptr_i(ptr),
    .cmp_i, .trial_o(dac_code_o), .final_o(final_code)
  );

  sar_outbuf #(.N(N)) u_buf (
    .clk_i, .rst_ni, .last_i(last), .final_i(final_code),
    .result_o, .done_o
  );

  assign ser_bit_o = busy_o & cmp_i;
  assign ser_vld_o = busy_o;

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sar_ctrl;
  localparam int N = 8;
  localparam int MAXC = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [N-1:0] dac_code, result;
  logic busy, done, ser_bit, ser_vld;
  int level = 0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  assign cmp = (level >= int'(dac_code));

  sar_ctrl #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .dac_code_o(dac_code), .busy_o(busy), .done_o(done), .result_o(result),
    .ser_bit_o(ser_bit), .ser_vld_o(ser_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v < 0) ? 0 : (v > MAXC) ? MAXC : v;
  endfunction

  // hold_start: keep start high through the busy window (R8)
  task automatic convert(input int lvl, input int prev, input bit hold_start);
    int exp = clampv(lvl);
    level = lvl;
    start = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    check(dac_code === N'(1 << (N - 1)), "R2 msb trial", dac_code, 1 << (N - 1));
    if (!hold_start) start = 1'b0;
    for (int k = 0; k < N; k++) begin
      int b = (exp >> (N - 1 - k)) & 1;
      if (k == N - 1) start = 1'b0;
      check(busy === 1'b1, "R4 busy width", busy, 1);
      check(ser_vld === 1'b1, "R7 serial valid", ser_vld, 1);
      check(ser_bit === 1'(b), "R7 serial bit", ser_bit, b);
      check(result === N'(prev), "R6 buffer holds", result, prev);
      check(done === 1'b0, "R5 no early done", done, 0);
      @(negedge clk);
    end
    check(busy === 1'b0, "R4 busy ends after N", busy, 0);
    check(done === 1'b1, "R5 done pulse", done, 1);
    check(result === N'(exp), hold_start ? "R8 result with held start" : "R3 result", result, exp);
    check(ser_vld === 1'b0, "R7 idle valid", ser_vld, 0);
    @(negedge clk);
    check(done === 1'b0, "R5 done single", done, 0);
    check(busy === 1'b0, "R8 no restart", busy, 0);
    check(result === N'(exp), "R6 result stable", result, exp);
  endtask

  initial begin
    int prev = 0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && ser_vld === 1'b0, "R1 flags in reset", busy, 0);
    check(result === '0 && dac_code === '0, "R1 regs in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && result === '0, "R1 after reset", result, 0);
    for (int v = 0; v <= MAXC; v++) begin
      convert(v, prev, 1'b0);
      prev = v;
    end
    convert(-5, prev, 1'b0); prev = 0;
    convert(MAXC + 40, prev, 1'b0); prev = MAXC;
    convert(77, prev, 1'b1); prev = 77;
    convert(200, prev, 1'b1); prev = 200;
    convert(55, prev, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule